// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block gathers every reset cause of a small microcontroller core into one system reset. The causes are a falling edge on the external active-low reset pad, a decoded software-reset opcode, an idle/powerdown request carrying an illegal key, a watchdog overflow, and an oscillator-failure request that only counts when its enable bit is set. Any of these starts an open-drain pull-down on the reset pad. The pull-down lasts a fixed number of state times, and a state time is two clock periods.

The pad is level-sensitive as an input. The block treats its own pull-down and an externally held-low pad the same way: both keep the core in reset. While reset is active, `sys_reset` holds the special function registers at their defaults. When the pad level finally rises, the block gives a one-cycle load strobe. That strobe reloads the program counter with the reset vector and clears the status word. On the same edge it samples the active-low emulation strap. A low strap floats every pin until the next reset. A cause register records which source or sources started the most recent pulse.

Top module: `mcu_reset_seq`

## Requirements
- R1: A request seen at a clock edge turns on `rst_pin_pull` from that edge on. With no further request, the pull-down stays on for exactly 32 clock cycles (16 state times of 2 clocks each).
- R2: `op_valid` with `op_code` = 8'hFF is a reset request. `op_valid` with any other code is ignored.
- R3: `pm_valid` with `pm_key` equal to 8'h01 (idle) or 8'h02 (powerdown) is ignored. Any other key value is a reset request.
- R4: A one-cycle `wdt_overflow` pulse is a reset request.
- R5: `osc_fail` is a reset request only when `osc_fail_en` (bit 0 of the user configuration byte) is 1. Otherwise it is ignored.
- R6: The pad input passes through a 2-flop synchronizer. A falling edge on the pad starts the pull-down two edges later. A pad held low by outside logic keeps `sys_reset` high after the pull-down has ended.
- R7: A new request while the pull-down is on restarts the full 32-cycle count.
- R8: `sys_reset` is the registered reset level (pull-down on or pad low). In the cycle where `sys_reset` falls, `vec_load` is high for exactly one cycle and `vec_pc` reads 16'h2080.
- R9: `emu_strap_n` is sampled at the release edge. `pins_float` becomes 1 if the strap was 0 and holds until the next reset, which clears it.
- R10: `reset_cause` bit 0 = pad, 1 = software opcode, 2 = illegal key, 3 = watchdog, 4 = oscillator fail. Each request replaces the register with the set of sources active in that cycle. Ignored inputs leave it unchanged.
- R11: After `rst_n` low, `rst_pin_pull`, `sys_reset`, `vec_load`, `pins_float` and `reset_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| ext_pin_n | input | 1 | Level read from the reset pad, driven from outside |
| op_valid | input | 1 | Decoded instruction strobe |
| op_code | input | 8 | Opcode of the decoded instruction |
| pm_valid | input | 1 | Idle/powerdown request strobe |
| pm_key | input | 8 | Key operand of that request |
| wdt_overflow | input | 1 | One-cycle watchdog overflow request |
| osc_fail | input | 1 | One-cycle oscillator-failure request |
| osc_fail_en | input | 1 | Oscillator-failure reset enable |
| emu_strap_n | input | 1 | Active-low emulation strap |
| rst_pin_pull | output | 1 | Open-drain pull-down enable for the reset pad |
| sys_reset | output | 1 | Core reset; SFRs held at defaults while high |
| vec_load | output | 1 | One-cycle strobe: load PC, clear status word |
| vec_pc | output | 16 | Reset vector |
| pins_float | output | 1 | All pins to high impedance |
| reset_cause | output | 5 | Source(s) of the most recent reset pulse |

## Verification
On every cycle the assertions check these relations: a request turns on the pull-down, the pull-down never runs past its 32-cycle window, the load strobe lines up with the falling edge of `sys_reset`, the float flag rises only on a release with the strap low, and the cause register changes only on a request. Some behaviours only the bench's scenarios can show. These are the exact pulse width after a restart, the decoding of legal and illegal keys and opcodes, the gating of the oscillator request by its enable, and the pad held low past the pulse. They also include the float flag persisting after the strap changes, and the reset vector value.

// File: rtl/rstseq_pkg.sv
// Package: shared cause encoding for the reset sequencer.
// Assumes five reset sources; bit positions are visible to software.
package rstseq_pkg;
    localparam int CAUSE_PIN = 0;
    localparam int CAUSE_SW  = 1;
    localparam int CAUSE_KEY = 2;
    localparam int CAUSE_WDT = 3;
    localparam int CAUSE_OSC = 4;
    localparam int NUM_CAUSES = 5;
    typedef logic [NUM_CAUSES-1:0] cause_t;
endpackage

// File: rtl/rstseq_src_decode.sv
// Module: turns raw reset sources into a per-cycle request vector.
// Synchronizes the pad level and detects its falling edge. It also
// decodes the software opcode, the power-mode key and the gated
// oscillator request. Assumes the internal requests are one-cycle
// pulses already in the clk domain.
module rstseq_src_decode
    import rstseq_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] OP_RESET    = 8'hFF,
    parameter logic [7:0] KEY_IDLE    = 8'h01,
    parameter logic [7:0] KEY_PDOWN   = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_pin_n,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    input  logic       pm_valid,
    input  logic [7:0] pm_key,
    input  logic       wdt_ovf,
    input  logic       osc_fail,
    input  logic       osc_en,
    output logic       pin_lvl_n,
    output cause_t     src
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_prev_q;
    logic                   key_legal;

    // Synchronizer chain for the asynchronous pad level (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin_n};
    end

    // Previous synchronized level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev_q <= 1'b1;
        else        pin_prev_q <= pin_lvl_n;
    end

    assign pin_lvl_n = sync_q[SYNC_STAGES-1];
    assign key_legal = (pm_key == KEY_IDLE) || (pm_key == KEY_PDOWN);

    // Build the request vector from all five sources.
    always_comb begin
        src            = '0;
        src[CAUSE_PIN] = pin_prev_q & ~pin_lvl_n;
        src[CAUSE_SW]  = op_valid & (op_code == OP_RESET);
        src[CAUSE_KEY] = pm_valid & ~key_legal;
        src[CAUSE_WDT] = wdt_ovf;
        src[CAUSE_OSC] = osc_fail & osc_en;
    end
endmodule

// File: rtl/rstseq_pulse_timer.sv
// Module: fixed-length pull-down generator.
// A start restarts a prescaler and a state-time counter. The pull stays
// on for STATE_TIMES * CLKS_PER_STATE clocks after the last start.
// Assumes CLKS_PER_STATE >= 2 and STATE_TIMES >= 2.
module rstseq_pulse_timer #(
    parameter int STATE_TIMES    = 16,
    parameter int CLKS_PER_STATE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pull
);
    localparam int PH_W  = $clog2(CLKS_PER_STATE);
    localparam int CNT_W = $clog2(STATE_TIMES);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLKS_PER_STATE - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STATE_TIMES - 1);

    logic [PH_W-1:0]  phase_q;
    logic [CNT_W-1:0] st_cnt_q;
    logic             tick;

    assign tick = (phase_q == PH_LAST);

    // Prescale clocks into state times and count them while pulling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull     <= 1'b0;
            phase_q  <= '0;
            st_cnt_q <= '0;
        end else if (start) begin
            pull     <= 1'b1;
            phase_q  <= '0;
            st_cnt_q <= '0;
        end else if (pull) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
            if (tick) begin
                if (st_cnt_q == CNT_LAST) pull     <= 1'b0;
                else                      st_cnt_q <= st_cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rstseq_release.sv
// Module: reset level, release strobe, strap capture and cause register.
// Treats own pull-down and a low pad alike as "reset active". Assumes
// the strap is stable around the release edge.
module rstseq_release
    import rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pull,
    input  logic   pin_lvl_n,
    input  cause_t src,
    input  logic   strap_n,
    output logic   rst_lvl,
    output logic   rel_strobe,
    output logic   float_pins,
    output cause_t cause
);
    logic active;
    logic release_now;

    assign active      = pull | ~pin_lvl_n;
    assign release_now = rst_lvl & ~active;

    // Registered reset level and release strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_lvl    <= 1'b0;
            rel_strobe <= 1'b0;
        end else begin
            rst_lvl    <= active;
            rel_strobe <= release_now;
        end
    end

    // Strap captured on release, cleared by any new reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           float_pins <= 1'b0;
        else if (active)      float_pins <= 1'b0;
        else if (release_now) float_pins <= ~strap_n;
    end

    // Cause register replaced by each new request set.
    always_ff @(posedge clk) begin
        if (!rst_n)     cause <= '0;
        else if (|src)  cause <= src;
    end
endmodule

// File: rtl/mcu_reset_seq.sv
// Module: top of the reset sequencer.
// Merges the reset sources into one fixed-length open-drain pulse. It
// releases the core with a vector load and latches the emulation strap.
// Assumes requests arrive as one-cycle pulses on clk.
module mcu_reset_seq
    import rstseq_pkg::*;
#(
    parameter int          STATE_TIMES    = 16,
    parameter int          CLKS_PER_STATE = 2,
    parameter int          SYNC_STAGES    = 2,
    parameter logic [15:0] RESET_VECTOR   = 16'h2080,
    parameter logic [7:0]  OP_RESET       = 8'hFF,
    parameter logic [7:0]  KEY_IDLE       = 8'h01,
    parameter logic [7:0]  KEY_PDOWN      = 8'h02
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_pin_n,
    input  logic        op_valid,
    input  logic [7:0]  op_code,
    input  logic        pm_valid,
    input  logic [7:0]  pm_key,
    input  logic        wdt_overflow,
    input  logic        osc_fail,
    input  logic        osc_fail_en,
    input  logic        emu_strap_n,
    output logic        rst_pin_pull,
    output logic        sys_reset,
    output logic        vec_load,
    output logic [15:0] vec_pc,
    output logic        pins_float,
    output logic [NUM_CAUSES-1:0] reset_cause
);
    localparam int PULSE_CYC = STATE_TIMES * CLKS_PER_STATE;

    cause_t src;
    cause_t cause_q;
    logic   pin_lvl_n;
    logic   req_any;

    rstseq_src_decode #(
        .SYNC_STAGES(SYNC_STAGES), .OP_RESET(OP_RESET),
        .KEY_IDLE(KEY_IDLE), .KEY_PDOWN(KEY_PDOWN)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n),
        .op_valid(op_valid), .op_code(op_code),
        .pm_valid(pm_valid), .pm_key(pm_key),
        .wdt_ovf(wdt_overflow), .osc_fail(osc_fail), .osc_en(osc_fail_en),
        .pin_lvl_n(pin_lvl_n), .src(src)
    );

    assign req_any = |src;

    rstseq_pulse_timer #(
        .STATE_TIMES(STATE_TIMES), .CLKS_PER_STATE(CLKS_PER_STATE)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(req_any), .pull(rst_pin_pull)
    );

    rstseq_release u_rel (
        .clk(clk), .rst_n(rst_n), .pull(rst_pin_pull), .pin_lvl_n(pin_lvl_n),
        .src(src), .strap_n(emu_strap_n), .rst_lvl(sys_reset),
        .rel_strobe(vec_load), .float_pins(pins_float), .cause(cause_q)
    );

    assign reset_cause = cause_q;
    assign vec_pc      = RESET_VECTOR;
endmodule

// File: rtl/mcu_reset_seq_chk.sv
// Module: assertion checker bound to mcu_reset_seq.
// Tracks the pulse window with its own counter instead of deep $past.
module mcu_reset_seq_chk #(
    parameter int PULSE_CYC = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_any,
    input logic       rst_pin_pull,
    input logic       sys_reset,
    input logic       vec_load,
    input logic       pins_float,
    input logic       emu_strap_n,
    input logic [4:0] reset_cause
);
    localparam int CW = $clog2(PULSE_CYC + 2) + 1;
    logic [CW-1:0] win_q;

    // Cycles since the last request while the pull-down is on.
    always_ff @(posedge clk) begin
        if (!rst_n)            win_q <= '0;
        else if (req_any)      win_q <= CW'(1);
        else if (rst_pin_pull) win_q <= win_q + 1'b1;
        else                   win_q <= '0;
    end

    // R1
    req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |=> rst_pin_pull);
    // R1
    pulse_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_pull |-> (win_q >= CW'(1) && win_q <= CW'(PULSE_CYC)));
    // R7
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pin_pull && win_q == CW'(PULSE_CYC) && !req_any) |=> !rst_pin_pull);
    // R8
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> $fell(sys_reset));
    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_reset) |-> vec_load);
    // R9
    float_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_float) |-> (vec_load && !$past(emu_strap_n)));
    // R9
    float_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |-> !pins_float);
    // R10
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |=> (reset_cause != 5'd0));
    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_any |=> $stable(reset_cause));
endmodule

bind mcu_reset_seq mcu_reset_seq_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_any(req_any), .rst_pin_pull(rst_pin_pull),
    .sys_reset(sys_reset), .vec_load(vec_load), .pins_float(pins_float),
    .emu_strap_n(emu_strap_n), .reset_cause(reset_cause)
);

// File: tb/mcu_reset_seq_test.sv
// Bench: directed corner cases plus seeded random request mixes.
module mcu_reset_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin_n = 1'b1;
    logic op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic pm_valid = 1'b0;
    logic [7:0] pm_key = 8'h00;
    logic wdt_overflow = 1'b0;
    logic osc_fail = 1'b0;
    logic osc_fail_en = 1'b0;
    logic emu_strap_n = 1'b1;
    logic rst_pin_pull, sys_reset, vec_load, pins_float;
    logic [15:0] vec_pc;
    logic [4:0] reset_cause;

    int tests = 0;
    int fails = 0;
    int seed_dummy;

    always #4 clk = ~clk;

    mcu_reset_seq uut (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n),
        .op_valid(op_valid), .op_code(op_code), .pm_valid(pm_valid),
        .pm_key(pm_key), .wdt_overflow(wdt_overflow), .osc_fail(osc_fail),
        .osc_fail_en(osc_fail_en), .emu_strap_n(emu_strap_n),
        .rst_pin_pull(rst_pin_pull), .sys_reset(sys_reset),
        .vec_load(vec_load), .vec_pc(vec_pc), .pins_float(pins_float),
        .reset_cause(reset_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected request set from the requirement encodings (R2-R5, R10).
    function automatic logic [4:0] exp_src(input logic ov, input logic [7:0] oc,
                                           input logic kv, input logic [7:0] k,
                                           input logic w, input logic o, input logic en);
        logic [4:0] s;
        s = 5'd0;
        s[1] = ov && (oc == 8'hFF);
        s[2] = kv && (k != 8'h01) && (k != 8'h02);
        s[3] = w;
        s[4] = o && en;
        return s;
    endfunction

    task automatic clear_reqs();
        op_valid = 0; pm_valid = 0; wdt_overflow = 0; osc_fail = 0;
    endtask

    // Called just after the negedge following the request edge.
    task automatic run_pulse(input string tag, input int w0, input int exp_w,
                             input logic [4:0] exp_cause, input logic exp_float);
        int w = w0;
        while (w < 500) begin
            @(negedge clk);
            if (!rst_pin_pull) break;
            w++;
        end
        chk({tag, " R1 pulse width"}, w, exp_w);
        chk({tag, " R8 sys_reset held at pull end"}, sys_reset, 1);
        @(negedge clk);
        chk({tag, " R8 sys_reset released"}, sys_reset, 0);
        chk({tag, " R8 vec_load strobe"}, vec_load, 1);
        chk({tag, " R8 vector"}, vec_pc, 16'h2080);
        chk({tag, " R9 float"}, pins_float, exp_float);
        @(negedge clk);
        chk({tag, " R8 vec_load one cycle"}, vec_load, 0);
        chk({tag, " R10 cause"}, reset_cause, exp_cause);
    endtask

    task automatic idle_check(input string tag, input logic [4:0] old_cause);
        repeat (5) @(negedge clk);
        chk({tag, " no pull"}, rst_pin_pull, 0);
        chk({tag, " R10 cause kept"}, reset_cause, old_cause);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [4:0] s;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 pull", rst_pin_pull, 0);
        chk("R11 sys_reset", sys_reset, 0);
        chk("R11 vec_load", vec_load, 0);
        chk("R11 float", pins_float, 0);
        chk("R11 cause", reset_cause, 0);

        // R4 watchdog
        wdt_overflow = 1; @(negedge clk); clear_reqs();
        chk("R4 pull on", rst_pin_pull, 1);
        run_pulse("R4", 1, 32, 5'b01000, 0);

        // R2 software opcode, then non-reset opcode
        op_valid = 1; op_code = 8'hFF; @(negedge clk); clear_reqs();
        chk("R2 pull on", rst_pin_pull, 1);
        run_pulse("R2", 1, 32, 5'b00010, 0);
        op_valid = 1; op_code = 8'h7F; @(negedge clk); clear_reqs();
        idle_check("R2 other opcode", 5'b00010);

        // R3 legal keys ignored, illegal key resets
        pm_valid = 1; pm_key = 8'h01; @(negedge clk); clear_reqs();
        idle_check("R3 key idle", 5'b00010);
        pm_valid = 1; pm_key = 8'h02; @(negedge clk); clear_reqs();
        idle_check("R3 key pdown", 5'b00010);
        pm_valid = 1; pm_key = 8'h05; @(negedge clk); clear_reqs();
        chk("R3 pull on", rst_pin_pull, 1);
        run_pulse("R3", 1, 32, 5'b00100, 0);

        // R5 oscillator gated by enable
        osc_fail_en = 0; osc_fail = 1; @(negedge clk); clear_reqs();
        idle_check("R5 disabled", 5'b00100);
        osc_fail_en = 1; osc_fail = 1; @(negedge clk); clear_reqs();
        chk("R5 pull on", rst_pin_pull, 1);
        run_pulse("R5", 1, 32, 5'b10000, 0);

        // R7 restart mid-pulse
        wdt_overflow = 1; @(negedge clk); clear_reqs();
        repeat (9) @(negedge clk);
        op_valid = 1; op_code = 8'hFF; @(negedge clk); clear_reqs();
        run_pulse("R7", 11, 42, 5'b00010, 0);

        // R6 short pad pulse
        ext_pin_n = 0; repeat (3) @(negedge clk); ext_pin_n = 1;
        begin
            int t = 0;
            while (!rst_pin_pull && t < 8) begin @(negedge clk); t++; end
        end
        chk("R6 pad starts pull", rst_pin_pull, 1);
        run_pulse("R6", 1, 32, 5'b00001, 0);

        // R6 pad held low past the pulse
        ext_pin_n = 0;
        repeat (100) @(negedge clk);
        chk("R6 pull ended", rst_pin_pull, 0);
        chk("R6 sys_reset held by pad", sys_reset, 1);
        chk("R6 no vec_load yet", vec_load, 0);
        ext_pin_n = 1;
        begin
            int seen = 0;
            repeat (6) begin @(negedge clk); if (vec_load) seen++; end
            chk("R6 single release", seen, 1);
        end
        chk("R6 cause", reset_cause, 5'b00001);

        // R9 strap low floats pins until the next reset
        emu_strap_n = 0;
        wdt_overflow = 1; @(negedge clk); clear_reqs();
        run_pulse("R9 low strap", 1, 32, 5'b01000, 1);
        emu_strap_n = 1;
        repeat (20) @(negedge clk);
        chk("R9 float held", pins_float, 1);
        op_valid = 1; op_code = 8'hFF; @(negedge clk); clear_reqs();
        @(negedge clk);
        chk("R9 float cleared by reset", pins_float, 0);
        run_pulse("R9 high strap", 2, 32, 5'b00010, 0);

        // Random mixes of requests (R2-R5, R10)
        for (int i = 0; i < 60; i++) begin
            logic [4:0] old_c;
            logic ov, kv, w, o, en;
            logic [7:0] oc, k;
            ov = $urandom_range(0, 1);
            oc = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom);
            kv = $urandom_range(0, 1);
            k  = 8'($urandom_range(0, 4));
            w  = ($urandom_range(0, 3) == 0);
            o  = $urandom_range(0, 1);
            en = $urandom_range(0, 1);
            s = exp_src(ov, oc, kv, k, w, o, en);
            old_c = reset_cause;
            op_valid = ov; op_code = oc; pm_valid = kv; pm_key = k;
            wdt_overflow = w; osc_fail = o; osc_fail_en = en;
            @(negedge clk); clear_reqs();
            if (s != 0) begin
                chk("R10 random pull on", rst_pin_pull, 1);
                run_pulse("R10 random", 1, 32, s, 0);
            end else begin
                idle_check("R10 random ignored", old_c);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule